// File: doc/BRIEF.md
# Interrupt Level Priority Selector

This block decides which interrupt level, if any, a processor core should take next. It merges sixteen external request lines with a software-interrupt register into one set of pending levels. The two timer bits of that register do not stand for levels of their own: either one makes level 14 pending. The highest pending level that lies strictly above the core's current interrupt level becomes a trap request. The trap type it carries is a fixed external-interrupt base code with the level number in its low bits.

The trap logic drives the global interrupt enable, the current interrupt level, the trap nesting level and the trap type now in service. Another level is not raised while a nested handler is already serving a higher trap type. When nothing at all is pending, the request drops and the recorded trap type returns to zero. The decision is registered: the outputs reflect the inputs seen at the previous clock edge. A separate one-cycle wake pulse reports that some external line has just risen, so that a halted core can resume.

Top module: `irq_level_sel`

## Requirements
- R1: While reset is high and on the first edge after it, hard_req is 0, trap_type is 0x00 and wake is 0.
- R2: Level n (1 to 15) is pending when irq_lines[n] or soft_int[n] is 1; irq_lines[0] marks level 0; soft_int bits 0 and 16 never mark their own index as pending.
- R3: When soft_int[0] (tick timer) or soft_int[16] (system-tick timer) is 1, level 14 is pending.
- R4: When no level is pending, hard_req is 0 and trap_type is 0x00 after the next clock edge, whatever the enable, level and nesting inputs are.
- R5: With int_en high, the highest pending level L with L > cur_pil wins and, one edge later, gives trap_type = 0x40 | L and hard_req = 1, so levels 1 to 15 map to 0x41 to 0x4F.
- R6: With int_en high and no pending level above cur_pil, hard_req and trap_type keep their values.
- R7: With int_en low and some level pending, hard_req and trap_type keep their values.
- R8: When trap_lvl is non-zero and svc_tt is greater than the winning trap type, hard_req and trap_type keep their values; an equal or lower svc_tt does not block.
- R9: Once set, hard_req stays 1 until the pending set empties, including when the winner equals the recorded trap type.
- R10: wake is 1 for one cycle, one edge after any bit of irq_lines goes from 0 to 1; a line held high gives no further pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | External interrupt request lines, one per level |
| soft_int | input | 17 | Software-interrupt register; bit 0 tick timer, bit 16 system-tick timer |
| int_en | input | 1 | Global interrupt enable |
| cur_pil | input | 4 | Current processor interrupt level |
| trap_lvl | input | 3 | Current trap nesting level |
| svc_tt | input | 8 | Trap type now in service |
| hard_req | output | 1 | Hard interrupt request |
| trap_type | output | 8 | Recorded trap type of the request |
| wake | output | 1 | One-cycle pulse after an external line rises |

## Verification
A wrong recorded trap type shows up at trap_type on the very next edge. It can stay wrong for many cycles, because the register is only rewritten when the winner changes or the pending set empties. A stuck or lost request bit is visible on hard_req one cycle after the stimulus that should change it. It persists until the pending set empties, so the bench compares both outputs on every cycle against a model. Faults in nesting suppression or in the strict level comparison only appear under the matching trap_lvl, svc_tt and cur_pil combinations. Directed cases place these exactly at the boundaries, and random traffic mixes them.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int unsigned IRQ_LEVELS = 16;
  localparam int unsigned TT_WIDTH   = 8;
  localparam int unsigned TL_WIDTH   = 3;
  localparam logic [TT_WIDTH-1:0] TT_EXT_BASE = 8'h40;
  localparam int unsigned TICK_BIT   = 0;
  localparam int unsigned STICK_BIT  = 16;
  localparam int unsigned TIMER_LVL  = 14;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
  parameter int unsigned NLVL      = 16,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16,
  parameter int unsigned TIMER_LVL = 14
) (
  input  logic [NLVL-1:0]    irq_lines,
  input  logic [STICK_BIT:0] soft_int,
  output logic [NLVL-1:0]    pend
);
  logic             timer_any;
  logic [NLVL-1:0]  soft_lvl;
  logic [NLVL-1:0]  timer_vec;

  assign timer_any = soft_int[TICK_BIT] | soft_int[STICK_BIT];

  for (genvar gi = 0; gi < NLVL; gi++) begin : g_lvl
    if (gi == TICK_BIT || gi == STICK_BIT || gi > STICK_BIT) begin : g_masked
      assign soft_lvl[gi] = 1'b0;
    end else begin : g_pass
      assign soft_lvl[gi] = soft_int[gi];
    end
    if (gi == TIMER_LVL) begin : g_fold
      assign timer_vec[gi] = timer_any;
    end else begin : g_nofold
      assign timer_vec[gi] = 1'b0;
    end
  end

  assign pend = irq_lines | soft_lvl | timer_vec;
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int unsigned NLVL  = 16,
  parameter int unsigned LVL_W = 4
) (
  input  logic [NLVL-1:0]  pend,
  input  logic [LVL_W-1:0] cur_pil,
  output logic             hit,
  output logic [LVL_W-1:0] win_lvl
);
  logic [NLVL-1:0] cand;

  for (genvar gi = 0; gi < NLVL; gi++) begin : g_cand
    assign cand[gi] = pend[gi] && (LVL_W'(gi) > cur_pil);
  end

  // highest index wins: later iterations overwrite earlier ones
  always_comb begin
    hit     = 1'b0;
    win_lvl = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (cand[i]) begin
        hit     = 1'b1;
        win_lvl = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_req_ctl.sv
module irq_req_ctl #(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned TT_W  = 8,
  parameter int unsigned TL_W  = 3,
  parameter logic [TT_W-1:0] TT_BASE = 8'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend_any,
  input  logic             int_en,
  input  logic             hit,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [TT_W-1:0]  svc_tt,
  output logic             hard_req,
  output logic [TT_W-1:0]  trap_type
);
  logic [TT_W-1:0] new_tt;
  logic            nested_block;
  logic            take;

  assign new_tt       = TT_BASE | TT_W'(win_lvl);
  assign nested_block = (trap_lvl != '0) && (svc_tt > new_tt);
  assign take         = int_en && hit && !nested_block && (trap_type != new_tt);

  always_ff @(posedge clk) begin
    if (rst) begin
      hard_req  <= 1'b0;
      trap_type <= '0;
    end else if (!pend_any) begin
      hard_req  <= 1'b0;
      trap_type <= '0;
    end else if (take) begin
      hard_req  <= 1'b1;
      trap_type <= new_tt;
    end
  end
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det #(
  parameter int unsigned NLVL = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] irq_lines,
  output logic            wake
);
  logic [NLVL-1:0] lines_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      wake    <= 1'b0;
    end else begin
      lines_q <= irq_lines;
      wake    <= |(irq_lines & ~lines_q);
    end
  end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
  import irq_sel_pkg::*;
#(
  parameter int unsigned NLVL      = IRQ_LEVELS,
  parameter int unsigned TT_W      = TT_WIDTH,
  parameter int unsigned TL_W      = TL_WIDTH,
  parameter logic [TT_W-1:0] TT_BASE = TT_EXT_BASE,
  parameter int unsigned TICK_B    = TICK_BIT,
  parameter int unsigned STICK_B   = STICK_BIT,
  parameter int unsigned TMR_LVL   = TIMER_LVL,
  localparam int unsigned LVL_W    = $clog2(NLVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NLVL-1:0]    irq_lines,
  input  logic [STICK_B:0]   soft_int,
  input  logic               int_en,
  input  logic [LVL_W-1:0]   cur_pil,
  input  logic [TL_W-1:0]    trap_lvl,
  input  logic [TT_W-1:0]    svc_tt,
  output logic               hard_req,
  output logic [TT_W-1:0]    trap_type,
  output logic               wake
);
  logic [NLVL-1:0]  pend;
  logic             hit;
  logic [LVL_W-1:0] win_lvl;

  irq_pend_merge #(
    .NLVL(NLVL), .TICK_BIT(TICK_B), .STICK_BIT(STICK_B), .TIMER_LVL(TMR_LVL)
  ) u_merge (
    .irq_lines(irq_lines), .soft_int(soft_int), .pend(pend)
  );

  irq_prio_scan #(.NLVL(NLVL), .LVL_W(LVL_W)) u_scan (
    .pend(pend), .cur_pil(cur_pil), .hit(hit), .win_lvl(win_lvl)
  );

  irq_req_ctl #(
    .LVL_W(LVL_W), .TT_W(TT_W), .TL_W(TL_W), .TT_BASE(TT_BASE)
  ) u_ctl (
    .clk(clk), .rst(rst), .pend_any(|pend), .int_en(int_en), .hit(hit),
    .win_lvl(win_lvl), .trap_lvl(trap_lvl), .svc_tt(svc_tt),
    .hard_req(hard_req), .trap_type(trap_type)
  );

  irq_wake_det #(.NLVL(NLVL)) u_wake (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .wake(wake)
  );
endmodule

// File: rtl/irq_level_sel_chk.sv
module irq_level_sel_chk #(
  parameter int unsigned NLVL    = 16,
  parameter int unsigned SOFT_W  = 17,
  parameter int unsigned TT_W    = 8,
  parameter logic [TT_W-1:0] TT_BASE = 8'h40
) (
  input logic              clk,
  input logic              rst,
  input logic [NLVL-1:0]   irq_lines,
  input logic [SOFT_W-1:0] soft_int,
  input logic              int_en,
  input logic              hard_req,
  input logic [TT_W-1:0]   trap_type,
  input logic              wake
);
  logic none_pending;
  assign none_pending = (irq_lines == '0) && (soft_int == '0);

  // R4
  empty_clears_chk: assert property (@(posedge clk) disable iff (rst)
    none_pending |=> (!hard_req && trap_type == '0));

  // R7
  masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!int_en && !none_pending) |=> ($stable(hard_req) && $stable(trap_type)));

  // R5
  tt_encoding_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_type != '0) |-> (((trap_type & TT_BASE) == TT_BASE) && ((trap_type ^ TT_BASE) != '0)));

  // R5
  tt_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(trap_type) && trap_type != '0) |-> hard_req);

  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hard_req) |-> (trap_type == '0));

  // R10
  wake_source_chk: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(|irq_lines));
endmodule

bind irq_level_sel irq_level_sel_chk #(
  .NLVL(NLVL), .SOFT_W(STICK_B + 1), .TT_W(TT_W), .TT_BASE(TT_BASE)
) u_chk (
  .clk(clk), .rst(rst), .irq_lines(irq_lines), .soft_int(soft_int),
  .int_en(int_en), .hard_req(hard_req), .trap_type(trap_type), .wake(wake)
);

// File: tb/irq_level_sel_test.sv
module irq_level_sel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_lines = '0;
  logic [16:0] soft_int = '0;
  logic        int_en = 1'b0;
  logic [3:0]  cur_pil = '0;
  logic [2:0]  trap_lvl = '0;
  logic [7:0]  svc_tt = '0;
  logic        hard_req;
  logic [7:0]  trap_type;
  logic        wake;

  int n_chk = 0;
  int n_fail = 0;

  logic        m_req = 1'b0;
  logic [7:0]  m_tt = '0;
  logic        m_wake = 1'b0;
  logic [15:0] m_prev = '0;

  always #10 clk = ~clk;

  irq_level_sel uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .soft_int(soft_int),
    .int_en(int_en), .cur_pil(cur_pil), .trap_lvl(trap_lvl), .svc_tt(svc_tt),
    .hard_req(hard_req), .trap_type(trap_type), .wake(wake)
  );

  function automatic logic [15:0] exp_pend(input logic [15:0] l, input logic [16:0] s);
    logic [15:0] p;
    p = l | {s[15:1], 1'b0};
    if (s[0] || s[16]) p[14] = 1'b1;
    return p;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Advance one edge, updating the model from the requirements, then compare.
  task automatic cyc(input string tag);
    logic [15:0] p;
    logic [7:0]  ntt;
    logic        found;
    p = exp_pend(irq_lines, soft_int);
    if (p == '0) begin
      m_req = 1'b0; m_tt = '0;
    end else if (int_en) begin
      found = 1'b0; ntt = '0;
      for (int i = 15; i > int'(cur_pil); i--) begin
        if (!found && p[i]) begin
          found = 1'b1;
          ntt = 8'h40 | 8'(i);
        end
      end
      if (found && !(trap_lvl != 0 && svc_tt > ntt) && m_tt != ntt) begin
        m_tt = ntt; m_req = 1'b1;
      end
    end
    m_wake = |(irq_lines & ~m_prev);
    m_prev = irq_lines;
    @(posedge clk);
    #2;
    check({tag, " hard_req"}, {7'd0, hard_req}, {7'd0, m_req});
    check({tag, " trap_type"}, trap_type, m_tt);
    check({tag, " wake"}, {7'd0, wake}, {7'd0, m_wake});
  endtask

  task automatic clear_all();
    irq_lines = '0; soft_int = '0; trap_lvl = '0; svc_tt = '0; cur_pil = '0; int_en = 1'b1;
    cyc("R4 clear");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #2;
    check("R1 hard_req in reset", {7'd0, hard_req}, 8'd0);
    check("R1 trap_type in reset", trap_type, 8'h00);
    check("R1 wake in reset", {7'd0, wake}, 8'd0);
    rst = 1'b0;
    cyc("R1 first edge");

    // R5: single external line
    int_en = 1'b1; irq_lines = 16'h0020;
    cyc("R5 level5");
    check("R5 tt 0x45", trap_type, 8'h45);
    // R5: higher line takes over
    irq_lines = 16'h8020;
    cyc("R5 level15");
    check("R5 tt 0x4F", trap_type, 8'h4F);
    // R9: back to lower winner, request stays
    irq_lines = 16'h0020;
    cyc("R9 level5 again");
    check("R9 req held", {7'd0, hard_req}, 8'd1);
    clear_all();
    check("R4 cleared tt", trap_type, 8'h00);

    // R3: system-tick bit alone folds to 14
    soft_int = 17'h10000;
    cyc("R3 stick");
    check("R3 stick tt 0x4E", trap_type, 8'h4E);
    clear_all();
    soft_int = 17'h00001;
    cyc("R3 tick");
    check("R3 tick tt 0x4E", trap_type, 8'h4E);
    clear_all();

    // R2: software bit 3 is its own level
    soft_int = 17'h00008;
    cyc("R2 soft3");
    check("R2 soft3 tt", trap_type, 8'h43);
    // R2/R4: line 0 only, level 0 never wins but is pending
    soft_int = '0; irq_lines = 16'h0001;
    cyc("R2 line0 hold");
    check("R2 line0 keeps tt", trap_type, 8'h43);
    clear_all();

    // R6: strict comparison with cur_pil
    irq_lines = 16'h0208; cur_pil = 4'd9;
    cyc("R6 pil9 nothing above");
    check("R6 no raise", {7'd0, hard_req}, 8'd0);
    cur_pil = 4'd8;
    cyc("R6 pil8 raise 9");
    check("R6 tt 0x49", trap_type, 8'h49);
    cur_pil = 4'd15; irq_lines = 16'h8208;
    cyc("R6 pil15 hold");
    check("R6 tt still 0x49", trap_type, 8'h49);
    clear_all();

    // R7: disabled holds
    int_en = 1'b0; irq_lines = 16'h8000;
    cyc("R7 disabled");
    check("R7 no request", {7'd0, hard_req}, 8'd0);
    int_en = 1'b1;
    cyc("R7 enabled");
    clear_all();

    // R8: nesting suppression
    trap_lvl = 3'd1; svc_tt = 8'h4F; irq_lines = 16'h0400;
    cyc("R8 blocked");
    check("R8 blocked tt", trap_type, 8'h00);
    svc_tt = 8'h4A;
    cyc("R8 equal passes");
    check("R8 equal tt", trap_type, 8'h4A);
    trap_lvl = 3'd0; svc_tt = 8'h4F; irq_lines = 16'h0800;
    cyc("R8 tl0 ignores svc");
    check("R8 tl0 tt", trap_type, 8'h4B);
    clear_all();

    // R10: wake pulse on rise only
    irq_lines = 16'h0100;
    cyc("R10 rise");
    check("R10 pulse", {7'd0, wake}, 8'd1);
    cyc("R10 held");
    check("R10 no repeat", {7'd0, wake}, 8'd0);
    clear_all();

    // random traffic against the model (R2..R10)
    for (int k = 0; k < 800; k++) begin
      irq_lines = 16'($urandom & $urandom & $urandom);
      soft_int  = 17'($urandom & $urandom & $urandom & $urandom);
      if (($urandom % 6) == 0) begin irq_lines = '0; soft_int = '0; end
      int_en   = ($urandom % 5) != 0;
      cur_pil  = 4'($urandom);
      trap_lvl = (($urandom % 2) == 0) ? 3'd0 : 3'($urandom);
      svc_tt   = 8'h40 | 8'($urandom % 16);
      cyc("R5 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule